// File: doc/BRIEF.md
# Programmable Multi-Mode PWM Group

This block is one pulse-width modulation group with four outputs, organised as two pairs. It has a single timebase counter. The counter runs either as a sawtooth (edge-aligned) or as a triangle (center-aligned). Each output is produced by comparing the counter against a duty value. Software programs the block through a narrow register write port. Every write lands in a shadow copy. The active copy used by the comparators is refreshed from the shadows at the start of each period. In the double-update center-aligned mode, the duty values are also refreshed at the triangle's peak, so the rising and falling halves of a pulse can differ.

Each pair works in one of two ways. In the first, the second output of the pair is the inverse of the first, and both follow the pair's duty value. In the second, the four outputs run independently, each from its own duty value. Two single-cycle strobes mark the period start and the triangle peak. They let surrounding logic or a testbench observe when new values take effect.

Top module: `pwm_quad_group`

## Requirements
- R1: While reset is asserted and after it is released with the enable bit clear, all four outputs and both strobes are low.
- R2: Edge-aligned mode (control bit 1 = 0): the counter steps 0,1,...,P-1 and wraps, so one period is P cycles. An output is high while the counter is below its duty value. The outputs are registered: an output in a given cycle reflects the counter value of the preceding cycle. Period writes below 2 are taken as 2.
- R3: Center-aligned mode (control bit 1 = 1): the counter steps 0 up to P and then down to 1, so one period is 2P cycles. An output is high while the counter is below its duty value.
- R4: Writes to period (address 0), control mode bits (address 1, bits 1..3) and duty values (addresses 2..5) do not change the outputs until the next period start. At that point all shadows move to the active set.
- R5: In single-update center mode (control bit 2 = 0), a duty write made during a period has no effect at the triangle peak. The pulse stays symmetric about the peak.
- R6: In double-update center mode (control bit 2 = 1), the duty shadows are also moved to the active set at the triangle peak. The falling half of the period then uses the new values.
- R7: Paired mode (control bit 3 = 0): pair k (outputs 2k and 2k+1) uses the duty at address 2+2k. Output 2k+1 is the inverse of output 2k whenever the block is enabled.
- R8: Independent mode (control bit 3 = 1): output i uses the duty written at address 2+i, with no inversion.
- R9: A duty of 0 holds a direct output low for the whole period. A duty at or above P holds it high for the whole period, including the counter's peak and wrap cycles.
- R10: Clearing the enable bit (address 1, bit 0) forces all outputs low from the next cycle and holds the counter at 0. Setting it again starts a new period at once, with a period-start strobe and a shadow load.
- R11: The period-start strobe is high for one cycle while enabled with the counter at 0 and counting up. The midpoint strobe is high for one cycle, only in center mode, when the counter reaches P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address: 0 period, 1 control, 2..5 duty values |
| wr_data | input | CNT_W (12) | Write data |
| period_start | output | 1 | One-cycle strobe at the start of each period |
| period_mid | output | 1 | One-cycle strobe at the center-mode peak |
| pwm_out | output | 2*N_PAIRS (4) | PWM outputs |

## Verification
A wrong counter step or a missed reload shows up as a shifted edge on some output within one period, usually within a handful of cycles, because every output is compared cycle by cycle against an independent model. A reload taken at the wrong moment shows up by the next strobe. The error appears either as a pulse edge at the wrong count or as a strobe in the wrong cycle. Frequent random writes to shadows and mode bits are mixed with directed runs that hold duty values at 0 and above the period. This exposes any glitch at the peak and wrap points.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;

   // register addresses
   localparam int unsigned ADDR_PERIOD = 0;
   localparam int unsigned ADDR_CTRL   = 1;
   localparam int unsigned ADDR_DUTY0  = 2;

   // control bit positions
   localparam int unsigned CTRL_EN     = 0;
   localparam int unsigned CTRL_CENTER = 1;
   localparam int unsigned CTRL_DBL    = 2;
   localparam int unsigned CTRL_INDEP  = 3;

   localparam int unsigned MIN_PERIOD  = 2;

   typedef struct packed {
      logic center;
      logic dbl;
      logic indep;
   } pwm_mode_t;

endpackage

// File: rtl/pwm_grp_regs.sv
module pwm_grp_regs
   import pwm_grp_pkg::*;
#(
   parameter int unsigned CNT_W      = 12,
   parameter int unsigned N_OUT      = 4,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned RST_PERIOD = 100
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [CNT_W-1:0]            wr_data,
   input  logic                        load_start,
   input  logic                        load_mid,
   output logic                        en,
   output pwm_mode_t                   act_mode,
   output pwm_mode_t                   eff_mode,
   output logic [CNT_W-1:0]            act_period,
   output logic [CNT_W-1:0]            eff_period,
   output logic [N_OUT-1:0][CNT_W-1:0] eff_duty
);

   localparam logic [CNT_W-1:0] PER_FLOOR = CNT_W'(MIN_PERIOD);

   logic [CNT_W-1:0]            sh_period;
   pwm_mode_t                   sh_mode;
   logic [N_OUT-1:0][CNT_W-1:0] sh_duty;
   logic [N_OUT-1:0][CNT_W-1:0] act_duty;
   logic                        duty_reload;

   assign duty_reload = load_start || (load_mid && act_mode.dbl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en         <= 1'b0;
         sh_period  <= CNT_W'(RST_PERIOD);
         act_period <= CNT_W'(RST_PERIOD);
         sh_mode    <= '0;
         act_mode   <= '0;
         sh_duty    <= '0;
         act_duty   <= '0;
      end else begin
         if (load_start) begin
            act_period <= sh_period;
            act_mode   <= sh_mode;
         end
         if (duty_reload) begin
            act_duty <= sh_duty;
         end
         if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_PERIOD)) begin
               sh_period <= (wr_data < PER_FLOOR) ? PER_FLOOR : wr_data;
            end
            if (wr_addr == ADDR_W'(ADDR_CTRL)) begin
               en             <= wr_data[CTRL_EN];
               sh_mode.center <= wr_data[CTRL_CENTER];
               sh_mode.dbl    <= wr_data[CTRL_DBL];
               sh_mode.indep  <= wr_data[CTRL_INDEP];
            end
            for (int i = 0; i < int'(N_OUT); i++) begin
               if (wr_addr == ADDR_W'(ADDR_DUTY0 + i)) begin
                  sh_duty[i] <= wr_data;
               end
            end
         end
      end
   end

   // bypass: values loaded at this edge are already used in this cycle
   always_comb begin
      eff_period = load_start ? sh_period : act_period;
      eff_mode   = load_start ? sh_mode   : act_mode;
      eff_duty   = duty_reload ? sh_duty  : act_duty;
   end

   // R4
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_start |=> (act_mode == $past(act_mode)));

   // R2
   period_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (act_period >= PER_FLOOR));

endmodule

// File: rtl/pwm_grp_timebase.sv
module pwm_grp_timebase #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             eff_center,
   input  logic [CNT_W-1:0] eff_period,
   input  logic             act_center,
   input  logic [CNT_W-1:0] act_period,
   output logic [CNT_W-1:0] cnt,
   output logic             per_start,
   output logic             per_mid
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             down;
   logic [CNT_W-1:0] cnt_nxt;
   logic             down_nxt;

   assign per_start = en && (cnt == '0) && !down;
   assign per_mid   = en && act_center && !down && (cnt == act_period);

   always_comb begin
      cnt_nxt  = cnt;
      down_nxt = down;
      if (!en) begin
         cnt_nxt  = '0;
         down_nxt = 1'b0;
      end else if (down) begin
         if (cnt <= ONE) begin
            cnt_nxt  = '0;
            down_nxt = 1'b0;
         end else begin
            cnt_nxt = cnt - ONE;
         end
      end else if (eff_center) begin
         if (cnt >= eff_period) begin
            cnt_nxt  = cnt - ONE;
            down_nxt = 1'b1;
         end else begin
            cnt_nxt = cnt + ONE;
         end
      end else begin
         if (cnt >= eff_period - ONE) begin
            cnt_nxt = '0;
         end else begin
            cnt_nxt = cnt + ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         down <= 1'b0;
      end else begin
         cnt  <= cnt_nxt;
         down <= down_nxt;
      end
   end

   // R11
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_start |=> !per_start);

   // R11
   mid_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_mid |=> (down && !per_mid));

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !per_start) |-> (cnt <= act_period));

   // R10
   idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));

endmodule

// File: rtl/pwm_grp_cmp.sv
module pwm_grp_cmp #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             invert,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] duty,
   output logic             pwm_q
);

   logic hi;

   // saturating duty keeps peak and wrap cycles high
   assign hi = (duty >= period) || (cnt < duty);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_q <= 1'b0;
      end else begin
         pwm_q <= en && (hi ^ invert);
      end
   end

   // R9
   zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (duty == '0 && !invert) |=> !pwm_q);

   // R9
   full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && duty >= period && !invert) |=> pwm_q);

endmodule

// File: rtl/pwm_quad_group.sv
module pwm_quad_group
   import pwm_grp_pkg::*;
#(
   parameter int unsigned CNT_W      = 12,
   parameter int unsigned N_PAIRS    = 2,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned RST_PERIOD = 100
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [CNT_W-1:0]       wr_data,
   output logic                   period_start,
   output logic                   period_mid,
   output logic [2*N_PAIRS-1:0]   pwm_out
);

   localparam int unsigned N_OUT = 2 * N_PAIRS;

   if (CNT_W < 4) begin : g_bad_cnt_w
      $error("CNT_W must hold the four control bits");
   end
   if (ADDR_W < $clog2(ADDR_DUTY0 + N_OUT)) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the duty registers");
   end
   if (RST_PERIOD < MIN_PERIOD || RST_PERIOD >= (1 << CNT_W)) begin : g_bad_rst
      $error("RST_PERIOD out of range");
   end

   logic                        en;
   pwm_mode_t                   act_mode;
   pwm_mode_t                   eff_mode;
   logic [CNT_W-1:0]            act_period;
   logic [CNT_W-1:0]            eff_period;
   logic [N_OUT-1:0][CNT_W-1:0] eff_duty;
   logic [CNT_W-1:0]            cnt;

   pwm_grp_regs #(
      .CNT_W      (CNT_W),
      .N_OUT      (N_OUT),
      .ADDR_W     (ADDR_W),
      .RST_PERIOD (RST_PERIOD)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .load_start (period_start),
      .load_mid   (period_mid),
      .en         (en),
      .act_mode   (act_mode),
      .eff_mode   (eff_mode),
      .act_period (act_period),
      .eff_period (eff_period),
      .eff_duty   (eff_duty)
   );

   pwm_grp_timebase #(
      .CNT_W (CNT_W)
   ) u_timebase (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .eff_center (eff_mode.center),
      .eff_period (eff_period),
      .act_center (act_mode.center),
      .act_period (act_period),
      .cnt        (cnt),
      .per_start  (period_start),
      .per_mid    (period_mid)
   );

   for (genvar p = 0; p < int'(N_PAIRS); p++) begin : g_pair
      for (genvar s = 0; s < 2; s++) begin : g_side
         localparam int unsigned IDX = 2 * p + s;
         logic [CNT_W-1:0] duty_sel;
         logic             inv;

         assign duty_sel = eff_mode.indep ? eff_duty[IDX] : eff_duty[2*p];
         assign inv      = !eff_mode.indep && (s == 1);

         pwm_grp_cmp #(
            .CNT_W (CNT_W)
         ) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en),
            .invert (inv),
            .cnt    (cnt),
            .period (eff_period),
            .duty   (duty_sel),
            .pwm_q  (pwm_out[IDX])
         );
      end

      // R7
      pair_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !eff_mode.indep) |=> (pwm_out[2*p+1] == !pwm_out[2*p]));
   end

   // R10
   off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (pwm_out == '0));

   // R11
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({period_start, period_mid}));

endmodule

// File: tb/pwm_quad_group_bench.sv
`timescale 1ns/1ps
module pwm_quad_group_bench;

   localparam int CNT_W  = 12;
   localparam int NP     = 2;
   localparam int NO     = 2 * NP;
   localparam int ADDR_W = 3;
   localparam int RSTP   = 100;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [CNT_W-1:0]  wr_data = '0;
   logic              period_start;
   logic              period_mid;
   logic [NO-1:0]     pwm_out;

   always #2 clk = ~clk;

   pwm_quad_group #(
      .CNT_W (CNT_W), .N_PAIRS (NP), .ADDR_W (ADDR_W), .RST_PERIOD (RSTP)
   ) u_pwm_quad_group (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .period_start (period_start),
      .period_mid (period_mid), .pwm_out (pwm_out)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   string phase = "R1";

   // reference model state
   int m_en, m_cnt, m_dn;
   int sh_per, sh_cen, sh_dbl, sh_ind;
   int a_per, a_cen, a_dbl, a_ind;
   int sh_duty [NO];
   int a_duty  [NO];
   int m_out   [NO];

   function automatic int f_start();
      return (m_en != 0 && m_cnt == 0 && m_dn == 0) ? 1 : 0;
   endfunction

   function automatic int f_mid();
      return (m_en != 0 && a_cen != 0 && m_dn == 0 && m_cnt == a_per) ? 1 : 0;
   endfunction

   task automatic model_reset();
      m_en = 0; m_cnt = 0; m_dn = 0;
      sh_per = RSTP; a_per = RSTP;
      sh_cen = 0; sh_dbl = 0; sh_ind = 0;
      a_cen = 0; a_dbl = 0; a_ind = 0;
      for (int i = 0; i < NO; i++) begin
         sh_duty[i] = 0; a_duty[i] = 0; m_out[i] = 0;
      end
   endtask

   task automatic model_step(input int we, input int addr, input int data);
      int ps, md, e_per, e_cen, e_ind, d, h;
      int e_duty [NO];
      ps = f_start();
      md = f_mid();
      e_per = ps ? sh_per : a_per;
      e_cen = ps ? sh_cen : a_cen;
      e_ind = ps ? sh_ind : a_ind;
      for (int i = 0; i < NO; i++)
         e_duty[i] = (ps != 0 || (md != 0 && a_dbl != 0)) ? sh_duty[i] : a_duty[i];
      for (int i = 0; i < NO; i++) begin
         d = e_ind ? e_duty[i] : e_duty[i & ~1];
         h = (m_cnt < d || d >= e_per) ? 1 : 0;
         if (e_ind == 0 && (i % 2) == 1) h = 1 - h;
         m_out[i] = m_en ? h : 0;
      end
      if (ps) begin
         a_per = sh_per; a_cen = sh_cen; a_dbl = sh_dbl; a_ind = sh_ind;
      end
      if (ps != 0 || (md != 0 && a_dbl != 0 && ps == 0))
         for (int i = 0; i < NO; i++) a_duty[i] = sh_duty[i];
      if (!m_en) begin
         m_cnt = 0; m_dn = 0;
      end else if (m_dn) begin
         if (m_cnt <= 1) begin m_cnt = 0; m_dn = 0; end
         else m_cnt = m_cnt - 1;
      end else if (e_cen) begin
         if (m_cnt >= e_per) begin m_cnt = m_cnt - 1; m_dn = 1; end
         else m_cnt = m_cnt + 1;
      end else begin
         if (m_cnt >= e_per - 1) m_cnt = 0;
         else m_cnt = m_cnt + 1;
      end
      if (we) begin
         if (addr == 0) sh_per = (data < 2) ? 2 : data;
         if (addr == 1) begin
            m_en = data & 1; sh_cen = (data >> 1) & 1;
            sh_dbl = (data >> 2) & 1; sh_ind = (data >> 3) & 1;
         end
         if (addr >= 2 && addr < 2 + NO) sh_duty[addr-2] = data;
      end
   endtask

   task automatic check_now();
      logic [NO-1:0] exp_o;
      for (int i = 0; i < NO; i++) exp_o[i] = (m_out[i] != 0);
      n_vec++;
      if (pwm_out !== exp_o) begin
         n_bad++;
         $display("FAIL %s outputs act=%b exp=%b t=%0t", phase, pwm_out, exp_o, $time);
      end
      n_vec++;
      if ({period_start, period_mid} !== {f_start() != 0, f_mid() != 0}) begin
         n_bad++;
         $display("FAIL R11 strobes act=%b%b exp=%0d%0d t=%0t",
                  period_start, period_mid, f_start(), f_mid(), $time);
      end
   endtask

   task automatic cyc(input int we, input int addr, input int data);
      wr_en   = (we != 0);
      wr_addr = ADDR_W'(addr);
      wr_data = CNT_W'(data);
      model_step(we, addr, data);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      check_now();
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) cyc(0, 0, 0);
   endtask

   task automatic wr(input int addr, input int data);
      cyc(1, addr, data);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      int r, a, dv;
      void'($urandom(32'h5EED_0C1A));
      model_reset();
      repeat (3) @(negedge clk);
      // R1 reset state
      n_vec++;
      if (pwm_out !== '0 || period_start !== 1'b0 || period_mid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 in reset act=%b exp=0", pwm_out);
      end
      rst_n = 1'b1;
      @(negedge clk);
      check_now();
      idle(5);

      // R2 R7 edge, paired
      phase = "R2 R7";
      wr(0, 8); wr(2, 3); wr(4, 5); wr(1, 1);
      idle(30);
      // R4 shadow write mid-period
      phase = "R4";
      idle(3); wr(2, 6); wr(0, 1); idle(20); wr(0, 8); idle(20);

      // R3 R5 center, single update
      phase = "R3 R5";
      wr(1, 3); idle(20);
      wr(2, 2); idle(4); wr(4, 7); idle(40);

      // R6 double update
      phase = "R6";
      wr(1, 7);
      for (int k = 0; k < 8; k++) begin
         wr(2, k + 1); idle(5); wr(4, 8 - k); idle(3);
      end

      // R8 independent, center then edge
      phase = "R8";
      wr(2, 1); wr(3, 4); wr(4, 7); wr(5, 9); wr(1, 11);
      idle(40); wr(1, 9); idle(30);

      // R9 constant levels
      phase = "R9";
      wr(2, 0); wr(3, 8); wr(4, 20); wr(5, 4095);
      idle(30); wr(1, 11); idle(40);
      wr(1, 3); wr(2, 0); wr(4, 8); idle(40);

      // R10 disable and re-enable
      phase = "R10";
      wr(1, 0); idle(10); wr(2, 5); wr(1, 3); idle(25);
      wr(1, 2); idle(3); wr(1, 1); idle(15);

      // random mix, all requirements
      phase = "R2 R3 R4 R6 R7 R8 R9 R10";
      for (int k = 0; k < 6000; k++) begin
         r = int'($urandom % 16);
         if (r == 0) begin
            a  = int'($urandom % 6);
            if (a == 0) dv = int'($urandom % 25);
            else if (a == 1) dv = ((($urandom % 10) != 0) ? 1 : 0) | int'(($urandom % 8) << 1);
            else dv = int'($urandom % 30);
            wr(a, dv);
         end else begin
            idle(1);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule